// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block holds the on/off state of the 64 crosspoints of an 8-row by 8-column switch matrix. A six-bit address selects one crosspoint. Three bits pick the row and three bits pick the column. A single data bit says whether that crosspoint should close or open. A write happens while both an active-low chip select and an active-low write strobe are low. During that time the addressed enable output follows the data bit at once. When the strobe rises, the cell keeps the value the data bit had just before. Every other cell keeps its state.

An active-low clear input opens every switch, whatever the chip select is doing. Several copies can share address, data and strobe wiring, with a separate chip select for each copy, to build larger matrices. There is no path to read the memory back. The 64 enables come out as one flat vector for the analog switch drivers.

The cells are built as clocked storage with a combinational bypass. The bypass makes an open write window look transparent at the outputs. Inputs are sampled on the rising edge of `clk`. The value held when the strobe rises is therefore the data present at the last clock edge at which the strobe was still low.

Top module: `crosspoint_ctrl`

## Requirements
- R1: The enable output at bit index col_addr*8 + row_addr controls the switch joining row row_addr to column col_addr. The column address forms bits 5:3 of the index and the row address forms bits 2:0.
- R2: A cell can change only while cs_n = 0, stb_n = 0 and clr_n = 1 all hold together. With cs_n = 0 and stb_n = 1, no output changes.
- R3: While the write window is open, the addressed output equals data_in in the same cycle, with no clock delay. It follows data_in if data_in toggles.
- R4: After stb_n rises, the addressed cell keeps the data_in value sampled at the last clock edge with the window open. A data_in of 1 leaves the switch closed and 0 leaves it open. Later data_in changes have no effect. The address must stay constant while the strobe is low.
- R5: A write alters only the addressed output. The other 63 outputs keep their values.
- R6: While clr_n = 0, all 64 outputs are 0 at once, for any level of cs_n. The storage is cleared at the next clock edge, so outputs stay 0 after clr_n returns high.
- R7: While cs_n = 1, activity on stb_n, data_in and the address leaves all outputs unchanged.
- R8: Clear wins over a write in progress. A window held open during clear leaves every cell at 0 once clr_n returns high and the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| clr_n | input | 1 | Active-low clear of all cells |
| cs_n | input | 1 | Active-low chip select |
| stb_n | input | 1 | Active-low write strobe |
| data_in | input | 1 | Value for the addressed cell, 1 = closed |
| row_addr | input | 3 | Row select of the addressed crosspoint |
| col_addr | input | 3 | Column select of the addressed crosspoint |
| sw_en | output | 64 | Switch enables, index col*8+row |

## Verification
The bench toggles data_in while the strobe is held low. A design that registered the data instead of passing it through would lag by a cycle there. The bench then changes data_in right after the strobe rises, which catches a design that keeps the cell transparent for too long. It writes the corner cells 0 and 63 and a walking pattern, so swapped row and column fields or a decoder that hits more than one cell stand out against the reference model. It also drives strobe pulses with the chip deselected, and asserts clear in the middle of an open write window. Leaking writes, or a write that survives the clear, would show up as stray enables.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int ROW_BITS  = 3;
    localparam int COL_BITS  = 3;
    localparam int ADDR_BITS = ROW_BITS + COL_BITS;
    localparam int N_ROWS    = 1 << ROW_BITS;
    localparam int N_COLS    = 1 << COL_BITS;
    localparam int N_CELLS   = N_ROWS * N_COLS;

    // column in the upper field, row in the lower: index = col*N_ROWS + row
    typedef struct packed {
        logic [COL_BITS-1:0] col;
        logic [ROW_BITS-1:0] row;
    } xpt_addr_t;

    typedef struct packed {
        logic      open;   // window open and clear inactive
        logic      clear;  // master clear asserted
        logic      value;  // level to place in the cell
        xpt_addr_t addr;
    } wr_req_t;

    function automatic logic [ADDR_BITS-1:0] cell_index(input xpt_addr_t a);
        return {a.col, a.row};
    endfunction
endpackage

// File: rtl/xpt_wr_gate.sv
module xpt_wr_gate
    import xpt_pkg::*;
(
    input  logic                clr_n,
    input  logic                cs_n,
    input  logic                stb_n,
    input  logic                data_in,
    input  logic [ROW_BITS-1:0] row_addr,
    input  logic [COL_BITS-1:0] col_addr,
    output wr_req_t             req
);
    always_comb begin
        req.clear    = ~clr_n;
        req.open     = clr_n & ~cs_n & ~stb_n;
        req.value    = data_in;
        req.addr.col = col_addr;
        req.addr.row = row_addr;
    end
endmodule

// File: rtl/xpt_decoder.sv
module xpt_decoder
    import xpt_pkg::*;
#(
    parameter int CELLS = N_CELLS
) (
    input  wr_req_t           req,
    output logic [CELLS-1:0]  sel
);
    localparam int IW = $clog2(CELLS);

    for (genvar i = 0; i < CELLS; i++) begin : g_dec
        assign sel[i] = req.open && (IW'(cell_index(req.addr)) == IW'(i));
    end
endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array
    import xpt_pkg::*;
#(
    parameter int CELLS = N_CELLS
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              value,
    input  logic [CELLS-1:0]  sel,
    output logic [CELLS-1:0]  en
);
    logic [CELLS-1:0] held_q;

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (clear)       held_q[i] <= 1'b0;
            else if (sel[i]) held_q[i] <= value;
        end
        // bypass makes an open window transparent; clear masks at once
        assign en[i] = clear ? 1'b0 : (sel[i] ? value : held_q[i]);
    end
endmodule

// File: rtl/crosspoint_ctrl.sv
module crosspoint_ctrl
    import xpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 clr_n,
    input  logic                 cs_n,
    input  logic                 stb_n,
    input  logic                 data_in,
    input  logic [ROW_BITS-1:0]  row_addr,
    input  logic [COL_BITS-1:0]  col_addr,
    output logic [N_CELLS-1:0]   sw_en
);
    wr_req_t            req;
    logic [N_CELLS-1:0] sel;

    xpt_wr_gate u_gate (
        .clr_n    (clr_n),
        .cs_n     (cs_n),
        .stb_n    (stb_n),
        .data_in  (data_in),
        .row_addr (row_addr),
        .col_addr (col_addr),
        .req      (req)
    );

    xpt_decoder #(.CELLS(N_CELLS)) u_dec (
        .req (req),
        .sel (sel)
    );

    xpt_cell_array #(.CELLS(N_CELLS)) u_cells (
        .clk   (clk),
        .clear (req.clear),
        .value (req.value),
        .sel   (sel),
        .en    (sw_en)
    );
endmodule

// File: rtl/crosspoint_ctrl_chk.sv
module crosspoint_ctrl_chk
    import xpt_pkg::*;
(
    input logic                 clk,
    input logic                 clr_n,
    input logic                 cs_n,
    input logic                 stb_n,
    input logic                 data_in,
    input logic [ROW_BITS-1:0]  row_addr,
    input logic [COL_BITS-1:0]  col_addr,
    input logic [N_CELLS-1:0]   sw_en
);
    logic started = 1'b0;
    always_ff @(posedge clk) started <= 1'b1;

    p_clear_forces_off_r6: assert property (@(posedge clk)
        !clr_n |-> (sw_en == '0));

    p_follow_data_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (!cs_n && !stb_n) |-> (sw_en[{col_addr, row_addr}] == data_in));

    p_deselect_hold_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (started && cs_n && $past(cs_n) && $past(clr_n)) |-> $stable(sw_en));

    p_one_cell_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (started && $past(clr_n) && $stable({col_addr, row_addr}))
        |-> ($countones(sw_en ^ $past(sw_en)) <= 1));

    p_addr_steady_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (started && $past(!cs_n && !stb_n) && !cs_n && !stb_n)
        |-> $stable({col_addr, row_addr}));

    p_clear_wins_r8: assert property (@(posedge clk)
        (started && !$past(clr_n) && clr_n && (cs_n || stb_n)) |-> (sw_en == '0));
endmodule

bind crosspoint_ctrl crosspoint_ctrl_chk u_chk (.*);

// File: tb/crosspoint_ctrl_test.sv
module crosspoint_ctrl_test;
    logic        clk = 1'b0;
    logic        clr_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        stb_n = 1'b1;
    logic        data_in = 1'b0;
    logic [2:0]  row_addr = '0;
    logic [2:0]  col_addr = '0;
    logic [63:0] sw_en;

    int tests = 0;
    int fails = 0;
    bit ref_cell [64];

    always #2 clk = ~clk;   // 250 MHz

    crosspoint_ctrl uut (
        .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .stb_n(stb_n),
        .data_in(data_in), .row_addr(row_addr), .col_addr(col_addr),
        .sw_en(sw_en)
    );

    // behavioural reference: cells change at the sampling edge
    always @(posedge clk) begin
        if (!clr_n) begin
            for (int k = 0; k < 64; k++) ref_cell[k] = 1'b0;
        end else if (!cs_n && !stb_n) begin
            ref_cell[int'(col_addr) * 8 + int'(row_addr)] = data_in;
        end
    end

    function automatic logic [63:0] expected();
        logic [63:0] e;
        for (int k = 0; k < 64; k++) e[k] = ref_cell[k];
        if (!clr_n) return '0;
        if (!cs_n && !stb_n) e[int'(col_addr) * 8 + int'(row_addr)] = data_in;
        return e;
    endfunction

    task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: sw_en=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive after the edge, compare with the model mid-cycle
    task automatic step(input string req, input logic c, input logic s, input logic r,
                        input logic d, input int col, input int row);
        @(posedge clk);
        #1;
        cs_n = c; stb_n = s; clr_n = r; data_in = d;
        col_addr = 3'(col); row_addr = 3'(row);
        #1;
        cmp(req, sw_en, expected());
    endtask

    task automatic write_cell(input string req, input int col, input int row, input logic d);
        step(req, 1'b0, 1'b0, 1'b1, d, col, row);
        step(req, 1'b0, 1'b1, 1'b1, d, col, row);
        step(req, 1'b1, 1'b1, 1'b1, d, col, row);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R6: reset state
        step("R6", 1'b1, 1'b1, 1'b0, 1'b0, 0, 0);
        step("R6", 1'b1, 1'b1, 1'b0, 1'b0, 0, 0);
        cmp("R6", sw_en, 64'h0);

        // R1: column 5 row 2 lands on bit 42
        write_cell("R1", 5, 2, 1'b1);
        cmp("R1", sw_en, 64'h1 << 42);

        // R3: transparency while window open, data toggling
        step("R3", 1'b0, 1'b0, 1'b1, 1'b1, 3, 6);
        cmp("R3", {63'h0, sw_en[30]}, 64'h1);
        step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 3, 6);
        cmp("R3", {63'h0, sw_en[30]}, 64'h0);
        step("R3", 1'b0, 1'b0, 1'b1, 1'b1, 3, 6);
        step("R4", 1'b0, 1'b0, 1'b1, 1'b0, 3, 6);
        // R4: strobe rises, then data goes high: cell must stay 0
        step("R4", 1'b0, 1'b1, 1'b1, 1'b0, 3, 6);
        step("R4", 1'b0, 1'b1, 1'b1, 1'b1, 3, 6);
        step("R4", 1'b1, 1'b1, 1'b1, 1'b1, 3, 6);
        cmp("R4", sw_en, 64'h1 << 42);

        // R5/R1: corners and a walking diagonal
        write_cell("R5", 0, 0, 1'b1);
        write_cell("R5", 7, 7, 1'b1);
        cmp("R1", sw_en, (64'h1 << 63) | (64'h1 << 42) | 64'h1);
        for (int k = 0; k < 8; k++) write_cell("R5", k, 7 - k, 1'b1);
        write_cell("R5", 5, 2, 1'b0);
        write_cell("R5", 0, 0, 1'b0);

        // R2: chip selected, strobe high, data and address wander
        for (int k = 0; k < 8; k++) step("R2", 1'b0, 1'b1, 1'b1, k[0], k, k);

        // R7: deselected strobe pulses
        for (int k = 0; k < 16; k++)
            step("R7", 1'b1, k[0], 1'b1, ~k[1], k % 8, (k * 3) % 8);

        // R6: clear with chip deselected, then released
        step("R6", 1'b1, 1'b1, 1'b0, 1'b0, 0, 0);
        cmp("R6", sw_en, 64'h0);
        step("R6", 1'b1, 1'b1, 1'b1, 1'b0, 0, 0);
        cmp("R6", sw_en, 64'h0);

        // R8: clear during an open window
        write_cell("R8", 2, 4, 1'b1);
        step("R8", 1'b0, 1'b0, 1'b1, 1'b1, 6, 1);
        step("R8", 1'b0, 1'b0, 1'b0, 1'b1, 6, 1);
        cmp("R8", sw_en, 64'h0);
        step("R8", 1'b0, 1'b0, 1'b0, 1'b1, 6, 1);
        step("R8", 1'b0, 1'b1, 1'b0, 1'b1, 6, 1);
        step("R8", 1'b0, 1'b1, 1'b1, 1'b1, 6, 1);
        cmp("R8", sw_en, 64'h0);
        step("R8", 1'b1, 1'b1, 1'b1, 1'b0, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule